// File: doc/BRIEF.md
# Keyed XOR Index-Remapping Cache

This block is a direct-mapped, read-only cache that sits between a requester and a word-addressed backing memory. Every line holds exactly one 64-bit word, so a miss fetches only the word that was asked for and never a whole block. A protect input switches on a keyed placement: the request address is XORed with a per-client secret key before the set index and tag are split off. Consecutive words of one memory block then land in sets that no longer follow the address order, which breaks the link between a victim's address pattern and the sets an observer probes. The memory itself is always addressed with the original, unscrambled word address.

The key and the protect switch are plain configuration inputs. Any change to either invalidates the whole cache in one cycle, before the next request is taken, so no line filled under one mapping can hit under another. Every accepted request also produces a one-cycle hit or miss strobe together with the set that was looked up, for an external anomaly detector.

Top module: `keyed_remap_cache`

## Requirements
- R1: After reset, cpu_req_ready is 1, cpu_rsp_valid is 0, mem_req_valid is 0 and both access strobes are 0.
- R2: The effective address is cpu_req_addr XOR cfg_key when cfg_protect is 1 and cpu_req_addr otherwise; the set index is its low 10 bits and the tag its upper 6 bits, so two addresses with equal effective index and different effective tag evict each other.
- R3: A request whose line is valid with a matching tag is answered in the cycle after acceptance with cpu_rsp_valid=1, cpu_rsp_hit=1 and the stored word, and issues no memory read.
- R4: On a miss, mem_req_valid rises in the cycle after acceptance with mem_req_addr equal to the original (unscrambled) request address, and holds with a stable address until mem_rsp_valid; one cycle after that response the requester gets cpu_rsp_valid=1, cpu_rsp_hit=0 and the memory word.
- R5: A refill writes only the requested word: the neighbouring word address of a just-filled word still misses and causes its own memory read.
- R6: With protection on, the set looked up for address A is A[9:0] XOR key[9:0], so neighbouring words go to sets scattered by the key.
- R7: A change of cfg_protect or of cfg_key drops cpu_req_ready for one cycle and invalidates every line; an address cached before the change misses afterwards.
- R8: In the cycle after each accepted request exactly one of acc_hit and acc_miss is 1, with acc_set equal to the effective set index; both are 0 in every other cycle.
- R9: While a miss is outstanding, cpu_req_ready stays 0 for any memory latency and no further request is accepted.
- R10: With protection off, the key has no effect on placement: acc_set equals the low 10 address bits whatever cfg_key holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_protect | input | 1 | Enables keyed placement |
| cfg_key | input | 16 | Per-client placement key |
| cpu_req_valid | input | 1 | Read request present |
| cpu_req_addr | input | 16 | Word address of the request |
| cpu_req_ready | output | 1 | Request accepted when high with valid |
| cpu_rsp_valid | output | 1 | Read data valid, one cycle |
| cpu_rsp_data | output | 64 | Read data |
| cpu_rsp_hit | output | 1 | Response was served from the cache |
| mem_req_valid | output | 1 | Memory read outstanding |
| mem_req_addr | output | 16 | Original word address to fetch |
| mem_rsp_valid | input | 1 | Memory word returned, one cycle |
| mem_rsp_data | input | 64 | Memory word |
| acc_hit | output | 1 | Hit strobe for the detector |
| acc_miss | output | 1 | Miss strobe for the detector |
| acc_set | output | 10 | Set index of the strobed access |

## Verification
The assertions assume that the memory side answers only while mem_req_valid is high, with a single one-cycle mem_rsp_valid per read, and that configuration changes are seen as level changes on cfg_protect and cfg_key. The stimulus keeps to this through a memory model that waits for a request, delays a random zero to four cycles and pulses one response, and by changing configuration only between requests, at falling edges. Addresses are drawn from a small pool of tags and offsets so that hits, conflict evictions and neighbouring-word misses all occur often.

// File: rtl/xcache_pkg.sv
// Shared types for the keyed remapping cache.
// Assumes nothing beyond the enum encoding being free for synthesis to choose.
package xcache_pkg;

    // Controller states: waiting for a request, or waiting for a memory word
    typedef enum logic [0:0] {
        CS_IDLE = 1'b0,
        CS_FILL = 1'b1
    } ctrl_state_t;

endpackage

// File: rtl/xcache_remap.sv
// Placement function: turns a word address into set index and tag.
// When protection is on, the address is XORed with the key first; the
// mapping is its own inverse, so the same key recovers the address.
// Assumes KEY width equals address width.
module xcache_remap #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10,
    parameter bit KEYED  = 1'b1
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    protect,
    input  logic [ADDR_W-1:0]       key,
    output logic [IDX_W-1:0]        idx,
    output logic [ADDR_W-IDX_W-1:0] tag
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] eff;

    generate
        if (KEYED) begin : g_keyed
            // Apply the key only while protection is requested
            always_comb eff = protect ? (addr ^ key) : addr;
        end else begin : g_plain
            logic unused_cfg;
            // Plain placement variant: configuration is ignored
            always_comb begin
                eff        = addr;
                unused_cfg = protect ^ (^key);
            end
        end
    endgenerate

    // Split the effective address into its fields
    always_comb begin
        idx = eff[IDX_W-1:0];
        tag = eff[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/xcache_store.sv
// Line storage: one valid bit, a tag and one data word per line.
// Valid bits clear together on reset or flush; tag and data need no reset.
// Assumes write and flush never occur in the same cycle.
module xcache_store #(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  line_vld;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    // Valid bits: cleared as a whole, set one at a time by a refill
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            line_vld <= '0;
        end else if (wr_en) begin
            line_vld[wr_idx] <= 1'b1;
        end
    end

    // Tag and data arrays: written on refill only
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    // Asynchronous lookup of the addressed line
    always_comb begin
        rd_valid = line_vld[rd_idx];
        rd_tag   = tag_mem[rd_idx];
        rd_data  = data_mem[rd_idx];
    end
endmodule

// File: rtl/xcache_ctrl.sv
// Request controller: accepts a request, answers hits the next cycle,
// holds off new requests during a single-word refill, and emits the
// hit/miss strobe with the looked-up set.
// Assumes the memory answers once per read, only while mem_req_valid is high.
module xcache_ctrl #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_chg,
    output logic                    idle,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    req_ready,
    input  logic [IDX_W-1:0]        lk_idx,
    input  logic [ADDR_W-IDX_W-1:0] lk_tag,
    input  logic                    line_valid,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]       line_data,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    rsp_hit,
    output logic                    mem_req_valid,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    output logic                    acc_hit,
    output logic                    acc_miss,
    output logic [IDX_W-1:0]        acc_set
);
    import xcache_pkg::*;
    localparam int TAG_W = ADDR_W - IDX_W;

    ctrl_state_t       state;
    logic              accept;
    logic              lk_hit;
    logic [ADDR_W-1:0] miss_addr;
    logic [IDX_W-1:0]  miss_idx;
    logic [TAG_W-1:0]  miss_tag;

    // Handshake and tag compare for the request in flight
    always_comb begin
        idle      = (state == CS_IDLE);
        req_ready = idle && !cfg_chg;
        accept    = req_valid && req_ready;
        lk_hit    = line_valid && (line_tag == lk_tag);
    end

    // Memory side and refill write are driven straight from the fill state
    always_comb begin
        mem_req_valid = (state == CS_FILL);
        mem_req_addr  = miss_addr;
        wr_en         = (state == CS_FILL) && mem_rsp_valid;
        wr_idx        = miss_idx;
        wr_tag        = miss_tag;
    end

    // State, response and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CS_IDLE;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
            acc_hit   <= 1'b0;
            acc_miss  <= 1'b0;
            acc_set   <= '0;
            miss_addr <= '0;
            miss_idx  <= '0;
            miss_tag  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            acc_hit   <= 1'b0;
            acc_miss  <= 1'b0;
            case (state)
                CS_IDLE: begin
                    if (accept) begin
                        acc_set <= lk_idx;
                        if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_data  <= line_data;
                            acc_hit   <= 1'b1;
                        end else begin
                            acc_miss  <= 1'b1;
                            miss_addr <= req_addr;
                            miss_idx  <= lk_idx;
                            miss_tag  <= lk_tag;
                            state     <= CS_FILL;
                        end
                    end
                end
                CS_FILL: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        state     <= CS_IDLE;
                    end
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    // Response word on a refill comes from the memory bus via the write path
    logic [DATA_W-1:0] unused_ok;
    always_comb unused_ok = '0;
endmodule

// File: rtl/keyed_remap_cache.sv
// Top level: direct-mapped single-word-line cache with keyed XOR placement.
// Registers the configuration seen last; a difference flushes all lines
// while the controller is idle and blocks requests for that cycle.
// Assumes mem_rsp_data is valid whenever mem_rsp_valid is high.
module keyed_remap_cache #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_protect,
    input  logic [ADDR_W-1:0] cfg_key,
    input  logic              cpu_req_valid,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_data,
    output logic              cpu_rsp_hit,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              acc_hit,
    output logic              acc_miss,
    output logic [IDX_W-1:0]  acc_set
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              prot_q;
    logic [ADDR_W-1:0] key_q;
    logic              cfg_chg;
    logic              idle;
    logic              flush;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] rsp_word;
    logic              rsp_from_mem;
    logic [DATA_W-1:0] fill_word_q;

    // Detect a configuration change against the mapping in use
    always_comb begin
        cfg_chg = (cfg_protect != prot_q) || (cfg_key != key_q);
        flush   = cfg_chg && idle;
    end

    // Adopt the new mapping when the flush is applied
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            prot_q <= cfg_protect;
            key_q  <= cfg_key;
        end
    end

    xcache_remap #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .KEYED  (1'b1)
    ) remap_i (
        .addr    (cpu_req_addr),
        .protect (prot_q),
        .key     (key_q),
        .idx     (lk_idx),
        .tag     (lk_tag)
    );

    xcache_store #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_idx   (lk_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (line_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_data  (mem_rsp_data)
    );

    xcache_ctrl #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_chg       (cfg_chg),
        .idle          (idle),
        .req_valid     (cpu_req_valid),
        .req_addr      (cpu_req_addr),
        .req_ready     (cpu_req_ready),
        .lk_idx        (lk_idx),
        .lk_tag        (lk_tag),
        .line_valid    (line_valid),
        .line_tag      (line_tag),
        .line_data     (line_data),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_tag        (wr_tag),
        .rsp_valid     (cpu_rsp_valid),
        .rsp_data      (rsp_word),
        .rsp_hit       (cpu_rsp_hit),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .acc_hit       (acc_hit),
        .acc_miss      (acc_miss),
        .acc_set       (acc_set)
    );

    // Capture the refilled word for the response that follows it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_word_q  <= '0;
            rsp_from_mem <= 1'b0;
        end else begin
            rsp_from_mem <= wr_en;
            if (wr_en) begin
                fill_word_q <= mem_rsp_data;
            end
        end
    end

    // Select the response word: refill data or the stored line
    always_comb cpu_rsp_data = rsp_from_mem ? fill_word_q : rsp_word;
endmodule

// File: rtl/keyed_remap_cache_chk.sv
// Protocol checker for the keyed remapping cache, bound to the top module.
// Assumes a memory that answers only while a read is outstanding.
module keyed_remap_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_protect,
    input logic [ADDR_W-1:0] cfg_key,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_rsp_valid,
    input logic              cpu_rsp_hit,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              acc_hit,
    input logic              acc_miss
);
    // R3
    hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && cpu_rsp_hit) |-> $past(cpu_req_valid && cpu_req_ready));

    // R9
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    // R4
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4
    miss_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && !cpu_rsp_hit) |-> $past(mem_req_valid && mem_rsp_valid));

    // R8
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_hit, acc_miss}));

    // R8
    strobe_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit || acc_miss) == $past(cpu_req_valid && cpu_req_ready));

    // R7
    cfg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_protect != $past(cfg_protect)) || (cfg_key != $past(cfg_key))) |-> !cpu_req_ready);
endmodule

bind keyed_remap_cache keyed_remap_cache_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_protect   (cfg_protect),
    .cfg_key       (cfg_key),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_hit   (cpu_rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .acc_hit       (acc_hit),
    .acc_miss      (acc_miss)
);

// File: tb/keyed_remap_cache_tb_top.sv
// Bench: directed corner cases plus seeded random traffic against a
// reference placement model and a variable-latency memory model.
module keyed_remap_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int IDX_W      = 10;
    localparam int DATA_W     = 64;
    localparam int LINES      = 1 << IDX_W;
    localparam int TAG_W      = ADDR_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_protect = 1'b0;
    logic [ADDR_W-1:0] cfg_key = '0;
    logic              cpu_req_valid = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic              cpu_req_ready;
    logic              cpu_rsp_valid;
    logic [DATA_W-1:0] cpu_rsp_data;
    logic              cpu_rsp_hit;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic              acc_hit;
    logic              acc_miss;
    logic [IDX_W-1:0]  acc_set;

    int total = 0;
    int bad   = 0;
    int mem_reads = 0;
    int cycles = 0;
    logic             ref_vld [LINES];
    logic [TAG_W-1:0] ref_tag [LINES];

    keyed_remap_cache dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory content is a fixed function of the word address
    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a ^ 16'hC0DE, a, ~a, a ^ 16'h1234};
    endfunction

    // Effective address under the current configuration (R2)
    function automatic logic [ADDR_W-1:0] eff_addr(input logic [ADDR_W-1:0] a);
        return cfg_protect ? (a ^ cfg_key) : a;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ref_flush();
        for (int i = 0; i < LINES; i++) ref_vld[i] = 1'b0;
    endtask

    // Change configuration between requests; expect a one-cycle stall (R7)
    task automatic set_cfg(input logic p, input logic [ADDR_W-1:0] k);
        @(negedge clk);
        if (p != cfg_protect || k != cfg_key) begin
            cfg_protect = p;
            cfg_key     = k;
            #1;
            check(cpu_req_ready == 1'b0, "R7 ready drops on config change", 64'(cpu_req_ready), 64'd0);
            ref_flush();
        end
    endtask

    // One read request with full checking of strobes, data and memory traffic
    task automatic access(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] e;
        logic [IDX_W-1:0]  ix;
        logic [TAG_W-1:0]  tg;
        bit                exp_hit;
        int                reads0;
        int                wait_n;
        e  = eff_addr(a);
        ix = e[IDX_W-1:0];
        tg = e[ADDR_W-1 -: TAG_W];
        exp_hit = ref_vld[ix] && (ref_tag[ix] == tg);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        while (!cpu_req_ready) @(negedge clk);
        reads0 = mem_reads;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        check(acc_hit == exp_hit && acc_miss == !exp_hit, "R8 strobe kind",
              64'({acc_hit, acc_miss}), 64'({exp_hit, !exp_hit}));
        check(acc_set == ix, "R8 R6 R10 strobe set index", 64'(acc_set), 64'(ix));
        if (exp_hit) begin
            check(cpu_rsp_valid && cpu_rsp_hit, "R3 hit response next cycle",
                  64'({cpu_rsp_valid, cpu_rsp_hit}), 64'd3);
            check(cpu_rsp_data == mem_word(a), "R3 hit data", cpu_rsp_data, mem_word(a));
            check(!mem_req_valid && mem_reads == reads0, "R3 no memory read on hit",
                  64'(mem_reads - reads0), 64'd0);
        end else begin
            check(mem_req_valid && mem_req_addr == a, "R4 R2 miss reads original address",
                  64'(mem_req_addr), 64'(a));
            wait_n = 0;
            while (!cpu_rsp_valid && wait_n < 20) begin
                check(!cpu_req_ready, "R9 ready low during refill", 64'(cpu_req_ready), 64'd0);
                @(negedge clk);
                wait_n++;
            end
            check(cpu_rsp_valid && !cpu_rsp_hit, "R4 miss response", 64'({cpu_rsp_valid, cpu_rsp_hit}), 64'd2);
            check(cpu_rsp_data == mem_word(a), "R4 miss data", cpu_rsp_data, mem_word(a));
            check(mem_reads == reads0 + 1, "R5 one word read per miss", 64'(mem_reads - reads0), 64'd1);
            ref_vld[ix] = 1'b1;
            ref_tag[ix] = tg;
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Memory model: one response per read after a random delay
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                int lat;
                lat = $urandom % 5;
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(mem_req_addr);
                mem_reads++;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        ref_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cpu_req_ready && !cpu_rsp_valid && !mem_req_valid && !acc_hit && !acc_miss,
              "R1 reset state", 64'({cpu_req_ready, cpu_rsp_valid, mem_req_valid, acc_hit, acc_miss}),
              64'b10000);

        // R3 and R5: fill, hit, neighbour miss
        access(16'h0012);
        access(16'h0012);
        access(16'h0013);
        access(16'h0013);
        // R2: same index, different tag evicts
        access(16'h0412);
        access(16'h0012);
        // R10: key change with protection off flushes but keeps plain placement
        set_cfg(1'b0, 16'h03FF);
        access(16'h0012);
        access(16'h0012);
        // R6: protected placement, neighbours land on scrambled sets
        set_cfg(1'b1, 16'h0C03);
        access(16'h0012);
        access(16'h0013);
        access(16'h0012);
        // R2 under protection: 0x0412 still conflicts with 0x0012
        access(16'h0412);
        access(16'h0012);
        // R7: new key flushes, previously cached word misses
        set_cfg(1'b1, 16'h5A5A);
        access(16'h0012);
        set_cfg(1'b0, 16'h5A5A);
        access(16'h0012);

        // Random traffic with occasional reconfiguration
        for (int n = 0; n < 1500; n++) begin
            logic [ADDR_W-1:0] a;
            if (n % 97 == 96) set_cfg(1'($urandom), 16'($urandom));
            if ($urandom % 8 == 0) a = 16'($urandom);
            else a = 16'((($urandom % 6) << IDX_W) | ($urandom % 24));
            access(a);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule